// File: doc/BRIEF.md
# Frame Sync Protection Controller

This block keeps track of frame alignment on a serial bit stream in which every frame is 2048 bits long. At 2.048 Mbit/s that is one frame per millisecond. An external comparator marks each bit at which the sync word is recognised. The block decides whether that mark can be trusted and keeps a running bit position inside the frame. It raises an asynchronous flag whenever alignment is not established. Two counts make the decision stable against noise:

- a rear count: the number of consecutive confirmations needed before lock is declared;
- a front count: the number of consecutive misses tolerated before lock is dropped.

A second layer of the same kind tracks the master frame. It runs once per frame on one bit of the 16-bit control word that arrives with a valid strobe. It is only meaningful while frame lock holds, and a control bit can switch it off. Both input streams are plain strobes with no back-pressure: the block accepts every bit strobe and every control-word strobe in the cycle it is presented and never stalls its source. All outputs are registered on the rising clock edge that accepts the strobe.

Top module: `fsp_frame_sync`

## Requirements
- R1: While reset (active low) is applied and just after release: `async_flag`=1, `frame_start`=0, `bit_pos`=FRAME_BITS-1, `mf_locked`=0, `mf_index`=MF_FRAMES-1, `mf_start`=0.
- R2: Each cycle with `bit_en`=1 advances `bit_pos` by one, wrapping from FRAME_BITS-1 to 0. Without `bit_en` it holds. `frame_start` is high for exactly the one cycle after a bit that was given position 0.
- R3: While hunting (`async_flag`=1 and no confirmation in progress), a bit with `sync_hit`=1 is given position 0, so `bit_pos` reads 0 at once.
- R4: Lock (`async_flag`=0) is declared on the third consecutive frame in which `sync_hit` is present, counting the hunting hit as the first. A frame whose position-0 bit lacks `sync_hit` during this confirmation returns the block to hunting.
- R5: Once locked, `async_flag` rises when consecutive position-0 misses reach the front count selected by `front_sel`: 2'b11 gives 3, 2'b10 gives 5, 2'b01 gives 7, 2'b00 gives 9. Any position-0 hit clears the miss count.
- R6: While confirming or locked, `sync_hit` on any bit other than position 0 has no effect on `bit_pos` or `async_flag`.
- R7: The master-frame layer advances `mf_index` (0 to MF_FRAMES-1) on each `ctrl_valid` strobe, and only while frame lock holds. A marker is `ctrl_word` bit index 13 (the 14th bit, index 0 being the first) equal to 1. Master-frame lock (`mf_locked`=1) follows two consecutive master frames whose index-0 strobe carries the marker. A marker elsewhere during confirmation is ignored. `mf_start` pulses when `mf_index` becomes 0.
- R8: Once master-frame lock holds, it is dropped when consecutive index-0 marker misses reach the count chosen by `front_sel`: 2'b11 gives 7, 2'b10 gives 9, 2'b01 gives 11, 2'b00 gives 11.
- R9: While `mf_disable`=1, the master-frame layer is held cleared (`mf_locked`=0, `mf_index`=MF_FRAMES-1) from the next cycle on.
- R10: When `async_flag` is 1, `mf_locked` is 0 in the following cycle and the master-frame layer stays cleared. `ctrl_valid` strobes are ignored while `async_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit is presented this cycle |
| sync_hit | input | 1 | Sync word recognised at the presented bit |
| front_sel | input | 2 | Front protection select for both layers |
| mf_disable | input | 1 | 1 turns master-frame tracking off |
| ctrl_valid | input | 1 | Control word of the current frame is valid |
| ctrl_word | input | 16 | Per-frame control word |
| frame_start | output | 1 | One-cycle pulse after a position-0 bit |
| bit_pos | output | clog2(FRAME_BITS) | Position of the last accepted bit |
| async_flag | output | 1 | 1 when frame alignment is not established |
| mf_start | output | 1 | One-cycle pulse when the master-frame index wraps to 0 |
| mf_index | output | clog2(MF_FRAMES) | Frame index inside the master frame |
| mf_locked | output | 1 | Master-frame alignment established |

## Verification
`bit_pos`, `frame_start` and `async_flag` are due at the same rising edge that samples `bit_en`. `mf_index`, `mf_start` and `mf_locked` are due at the edge that samples `ctrl_valid`. The reaction of the master-frame layer to loss of frame lock or to `mf_disable` comes one edge later, because it passes through the registered lock state. The bench drives each strobe at the falling edge and reads the outputs one nanosecond after the next rising edge. For the delayed clear it waits one further edge before checking. A bench model advances one step per accepted bit, so every bit of the stream is compared at the exact cycle it is due.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int unsigned LIM_W = 4;

  typedef enum logic [1:0] {
    G_HUNT    = 2'd0,
    G_CONFIRM = 2'd1,
    G_LOCK    = 2'd2
  } guard_st_t;

  // Tolerated consecutive misses at frame level
  function automatic logic [LIM_W-1:0] frame_front(input logic [1:0] sel);
    unique case (sel)
      2'b11:   return LIM_W'(3);
      2'b10:   return LIM_W'(5);
      2'b01:   return LIM_W'(7);
      default: return LIM_W'(9);
    endcase
  endfunction

  // Tolerated consecutive misses at master-frame level
  function automatic logic [LIM_W-1:0] mf_front(input logic [1:0] sel);
    unique case (sel)
      2'b11:   return LIM_W'(7);
      2'b10:   return LIM_W'(9);
      default: return LIM_W'(11);
    endcase
  endfunction

endpackage

// File: rtl/fsp_front_decode.sv
module fsp_front_decode
  import fsp_pkg::*;
(
  input  logic [1:0]       front_sel,
  output logic [LIM_W-1:0] frame_lim,
  output logic [LIM_W-1:0] mf_lim
);

  always_comb begin
    frame_lim = frame_front(front_sel);
    mf_lim    = mf_front(front_sel);
  end

endmodule

// File: rtl/fsp_guard.sv
module fsp_guard
  import fsp_pkg::*;
#(
  parameter  int unsigned PERIOD = 2048,
  parameter  int unsigned REAR   = 3,
  localparam int unsigned PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int unsigned RW     = $clog2(REAR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             mark,
  input  logic [LIM_W-1:0] front_lim,
  output logic [PW-1:0]    pos,
  output logic             wrap,
  output logic             locked
);

  guard_st_t        st;
  logic [RW-1:0]    rear;
  logic [LIM_W-1:0] miss;
  logic [PW-1:0]    nxt_pos;
  logic             at_exp;

  always_comb begin
    nxt_pos = (32'(pos) == PERIOD - 1) ? '0 : pos + PW'(1);
    at_exp  = (nxt_pos == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= G_HUNT;
      pos  <= PW'(PERIOD - 1);
      rear <= '0;
      miss <= '0;
      wrap <= 1'b0;
    end else if (clr) begin
      st   <= G_HUNT;
      pos  <= PW'(PERIOD - 1);
      rear <= '0;
      miss <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (step) begin
        unique case (st)
          G_HUNT: begin
            if (mark) begin
              pos  <= '0;
              wrap <= 1'b1;
              miss <= '0;
              if (REAR <= 1) begin
                st   <= G_LOCK;
                rear <= '0;
              end else begin
                st   <= G_CONFIRM;
                rear <= RW'(1);
              end
            end else begin
              pos  <= nxt_pos;
              wrap <= at_exp;
            end
          end
          G_CONFIRM: begin
            pos  <= nxt_pos;
            wrap <= at_exp;
            if (at_exp) begin
              if (mark) begin
                if (int'(rear) + 1 >= int'(REAR)) begin
                  st   <= G_LOCK;
                  rear <= '0;
                  miss <= '0;
                end else begin
                  rear <= rear + RW'(1);
                end
              end else begin
                st   <= G_HUNT;
                rear <= '0;
              end
            end
          end
          G_LOCK: begin
            pos  <= nxt_pos;
            wrap <= at_exp;
            if (at_exp) begin
              if (mark) begin
                miss <= '0;
              end else if (int'(miss) + 1 >= int'(front_lim)) begin
                st   <= G_HUNT;
                miss <= '0;
              end else begin
                miss <= miss + LIM_W'(1);
              end
            end
          end
          default: st <= G_HUNT;
        endcase
      end
    end
  end

  assign locked = (st == G_LOCK);

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pos) < PERIOD);

  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(pos));

  // R2
  wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (pos == '0));

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(step && mark && !clr));

  // R5
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(clr || (step && !mark)));

endmodule

// File: rtl/fsp_frame_sync.sv
module fsp_frame_sync
  import fsp_pkg::*;
#(
  parameter  int unsigned FRAME_BITS = 2048,
  parameter  int unsigned FRAME_REAR = 3,
  parameter  int unsigned MF_FRAMES  = 16,
  parameter  int unsigned MF_REAR    = 2,
  parameter  int unsigned CTRL_W     = 16,
  parameter  int unsigned MF_BIT     = 13,
  localparam int unsigned PW         = $clog2(FRAME_BITS),
  localparam int unsigned MW         = $clog2(MF_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sync_hit,
  input  logic [1:0]        front_sel,
  input  logic              mf_disable,
  input  logic              ctrl_valid,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              frame_start,
  output logic [PW-1:0]     bit_pos,
  output logic              async_flag,
  output logic              mf_start,
  output logic [MW-1:0]     mf_index,
  output logic              mf_locked
);

  logic [LIM_W-1:0] frame_lim;
  logic [LIM_W-1:0] mf_lim;
  logic             frame_locked;
  logic             mf_clr;
  logic             mf_step;
  logic             unused_ctrl;

  fsp_front_decode u_dec (
    .front_sel (front_sel),
    .frame_lim (frame_lim),
    .mf_lim    (mf_lim)
  );

  fsp_guard #(
    .PERIOD (FRAME_BITS),
    .REAR   (FRAME_REAR)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (1'b0),
    .step      (bit_en),
    .mark      (sync_hit),
    .front_lim (frame_lim),
    .pos       (bit_pos),
    .wrap      (frame_start),
    .locked    (frame_locked)
  );

  assign mf_clr      = mf_disable | ~frame_locked;
  assign mf_step     = ctrl_valid & frame_locked;
  assign unused_ctrl = ^(ctrl_word & ~(CTRL_W'(1) << MF_BIT));

  fsp_guard #(
    .PERIOD (MF_FRAMES),
    .REAR   (MF_REAR)
  ) u_mf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mf_clr),
    .step      (mf_step),
    .mark      (ctrl_word[MF_BIT]),
    .front_lim (mf_lim),
    .pos       (mf_index),
    .wrap      (mf_start),
    .locked    (mf_locked)
  );

  assign async_flag = ~frame_locked;

  // R10
  mf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_flag |=> !mf_locked);

  // R9
  mf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_disable |=> !mf_locked);

  // R10
  mf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flag && $past(async_flag)) |=> (32'(mf_index) == MF_FRAMES - 1));

endmodule

// File: tb/test_fsp_frame_sync.sv
`timescale 1ns/100ps
module test_fsp_frame_sync;
  localparam int FB = 64;
  localparam int MF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        sync_hit = 1'b0;
  logic [1:0]  front_sel = 2'b11;
  logic        mf_disable = 1'b0;
  logic        ctrl_valid = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        frame_start, async_flag, mf_start, mf_locked;
  logic [5:0]  bit_pos;
  logic [2:0]  mf_index;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_st = 0;
  int m_pos = FB - 1;
  int m_rear = 0;
  int m_miss = 0;
  int m_fs = 0;

  always #2.5 clk = ~clk;

  fsp_frame_sync #(.FRAME_BITS(FB), .MF_FRAMES(MF)) i_fsp_frame_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_hit(sync_hit),
    .front_sel(front_sel), .mf_disable(mf_disable), .ctrl_valid(ctrl_valid),
    .ctrl_word(ctrl_word), .frame_start(frame_start), .bit_pos(bit_pos),
    .async_flag(async_flag), .mf_start(mf_start), .mf_index(mf_index),
    .mf_locked(mf_locked));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int fr_lim(input logic [1:0] s);
    return 9 - 2 * int'(s);
  endfunction

  function automatic int mf_lim(input logic [1:0] s);
    return (s == 2'b11) ? 7 : ((s == 2'b10) ? 9 : 11);
  endfunction

  // spec model: one step per accepted bit (R2..R6)
  task automatic mstep(input bit hit);
    int np;
    np = (m_pos == FB - 1) ? 0 : m_pos + 1;
    if (m_st == 0) begin
      if (hit) begin m_pos = 0; m_st = 1; m_rear = 1; m_miss = 0; end
      else m_pos = np;
    end else if (m_st == 1) begin
      m_pos = np;
      if (np == 0) begin
        if (hit) begin
          m_rear++;
          if (m_rear >= 3) begin m_st = 2; m_rear = 0; m_miss = 0; end
        end else begin m_st = 0; m_rear = 0; end
      end
    end else begin
      m_pos = np;
      if (np == 0) begin
        if (hit) m_miss = 0;
        else begin
          m_miss++;
          if (m_miss >= fr_lim(front_sel)) begin m_st = 0; m_miss = 0; end
        end
      end
    end
    m_fs = (m_pos == 0) ? 1 : 0;
  endtask

  task automatic send_bit(input bit hit, input string tag);
    @(negedge clk);
    bit_en = 1'b1; sync_hit = hit;
    @(posedge clk); #1;
    bit_en = 1'b0; sync_hit = 1'b0;
    mstep(hit);
    chk({tag, " bit_pos"}, int'(bit_pos), m_pos);
    chk({tag, " async_flag"}, int'(async_flag), (m_st != 2) ? 1 : 0);
    chk({tag, " frame_start"}, int'(frame_start), m_fs);
  endtask

  task automatic send_frame(input bit sync, input bit noise, input string tag);
    for (int i = 0; i < FB; i++) begin
      bit h;
      h = (sync && m_pos == FB - 1) ||
          (noise && m_st != 0 && m_pos != FB - 1 && ($urandom % 16) == 0);
      send_bit(h, tag);
    end
  endtask

  task automatic cv(input bit mark);
    @(negedge clk);
    ctrl_valid = 1'b1;
    ctrl_word = 16'($urandom);
    ctrl_word[13] = mark;
    @(posedge clk); #1;
    ctrl_valid = 1'b0;
  endtask

  task automatic mf_acquire();
    cv(1'b1);
    repeat (MF - 1) cv(1'b0);
    cv(1'b1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 async_flag", int'(async_flag), 1);
    chk("R1 frame_start", int'(frame_start), 0);
    chk("R1 bit_pos", int'(bit_pos), FB - 1);
    chk("R1 mf_locked", int'(mf_locked), 0);
    chk("R1 mf_index", int'(mf_index), MF - 1);
    chk("R1 mf_start", int'(mf_start), 0);

    // R2 free running, R3 realign on hunt hit
    repeat (10) send_bit(1'b0, "R2");
    send_bit(1'b1, "R3");
    chk("R3 realign", int'(bit_pos), 0);

    // R4 confirmation broken by a miss
    send_frame(1'b1, 1'b0, "R4");
    send_frame(1'b0, 1'b0, "R4");
    chk("R4 broken confirm", int'(async_flag), 1);
    send_frame(1'b1, 1'b0, "R4");
    chk("R4 one frame only", int'(async_flag), 1);

    // R5/R6 for every front select
    for (int s = 3; s >= 0; s--) begin
      int lim;
      front_sel = 2'(s);
      lim = fr_lim(front_sel);
      if (m_st == 0) send_bit(1'b1, "R3");
      for (int k = 0; k < 4 && m_st != 2; k++) send_frame(1'b1, 1'b1, "R6");
      chk("R4 locked", int'(async_flag), 0);
      repeat (lim - 1) send_frame(1'b0, 1'b1, "R5");
      send_frame(1'b1, 1'b1, "R5");
      repeat (lim - 1) send_frame(1'b0, 1'b1, "R5");
      chk("R5 hit clears misses", int'(async_flag), 0);
      send_frame(1'b0, 1'b1, "R5");
      chk("R5 loss at front count", int'(async_flag), 1);
    end

    // master frame layer
    front_sel = 2'b11;
    send_bit(1'b1, "R3");
    for (int k = 0; k < 4 && m_st != 2; k++) send_frame(1'b1, 1'b0, "R4");
    chk("R4 frame locked for MF", int'(async_flag), 0);

    @(negedge clk) mf_disable = 1'b1;
    mf_acquire();
    repeat (MF - 1) cv(1'b0);
    cv(1'b1);
    chk("R9 disabled not locked", int'(mf_locked), 0);
    chk("R9 disabled index held", int'(mf_index), MF - 1);
    @(negedge clk) mf_disable = 1'b0;

    cv(1'b1);
    chk("R7 marker index", int'(mf_index), 0);
    chk("R7 mf_start", int'(mf_start), 1);
    repeat (MF - 1) cv(1'b0);
    chk("R7 not yet locked", int'(mf_locked), 0);
    cv(1'b1);
    chk("R7 locked", int'(mf_locked), 1);
    repeat ((mf_lim(front_sel) - 1) * MF) cv(1'b0);
    chk("R8 sel11 still locked", int'(mf_locked), 1);
    repeat (MF) cv(1'b0);
    chk("R8 sel11 lost", int'(mf_locked), 0);

    front_sel = 2'b00;
    cv(1'b1);
    repeat (3) cv(1'b0);
    cv(1'b1);
    repeat (3) cv(1'b0);
    chk("R7 misplaced marker ignored", int'(mf_locked), 0);
    cv(1'b1);
    chk("R7 relock", int'(mf_locked), 1);
    repeat ((mf_lim(front_sel) - 1) * MF) cv(1'b0);
    chk("R8 sel00 still locked", int'(mf_locked), 1);
    repeat (MF) cv(1'b0);
    chk("R8 sel00 lost", int'(mf_locked), 0);

    // R10 frame loss clears master frame lock
    mf_acquire();
    chk("R10 mf locked before loss", int'(mf_locked), 1);
    for (int k = 0; k < 12 && m_st == 2; k++) send_frame(1'b0, 1'b0, "R10");
    @(posedge clk); #1;
    chk("R10 mf dropped", int'(mf_locked), 0);
    cv(1'b1);
    chk("R10 ctrl ignored index", int'(mf_index), MF - 1);
    chk("R10 ctrl ignored lock", int'(mf_locked), 0);

    // random sweep against the model
    for (int i = 0; i < 6000; i++) begin
      bit h;
      if (i % 700 == 0) front_sel = 2'($urandom);
      h = (m_pos == FB - 1) ? (($urandom % 4) != 0) : (($urandom % 64) == 0);
      send_bit(h, "R2 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule